// File: doc/BRIEF.md
# Narrow Floating-Point Adder

This block adds two 18-bit narrow floating-point words in a single combinational path and returns their sum. A word holds a sign bit, an 8-bit exponent stored with an offset of 128, and a 9-bit fractional mantissa with no hidden bit. The format has no rounding, no special values, no denormals and no error reporting. The block is meant for filter and codec datapaths where a short mantissa is enough and dynamic range comes from the exponent.

The adder orders the operands by magnitude. It shifts the smaller mantissa right to line up the binary points. It then adds or subtracts the mantissas according to the two signs and renormalises the result. Same-sign results are renormalised with at most one right shift. Opposite-sign results are renormalised with a left shift that brings the leading one back to the top bit. Subtraction is done by toggling the sign bit of one operand outside this block.

Top module: `nfp_add`

## Requirements
- R1: A word is laid out as {sign[17], exponent[16:9], mantissa[8:0]}. Its value is (mantissa/512)·2^(exponent−128), negated when the sign is 1. Every nonzero result has mantissa bit 8 set, and any result with mantissa bit 8 clear is the all-zero word.
- R2: When the signs match and the aligned mantissa sum stays below 512, the result takes the larger operand's exponent, the sum as its mantissa, and the common sign.
- R3: When the signs match and the aligned mantissa sum reaches 512 or more, the sum is shifted right one place and its lowest bit is dropped. The exponent rises by one and the common sign is kept.
- R4: The smaller-magnitude mantissa is shifted right by the exponent difference before combining, and the bits shifted out are lost. An exponent difference of 9 or more makes the smaller operand contribute nothing.
- R5: When the signs differ, the mantissa difference is shifted left until bit 8 is set. The exponent drops by one for every place shifted.
- R6: When the signs differ, the result takes the sign of the operand with the larger magnitude. Magnitude is compared by exponent first, then by mantissa. Swapping the two inputs never changes the output.
- R7: Two operands of equal magnitude and opposite sign give the all-zero word.
- R8: If left normalisation would need to take the exponent below 0, the output is the all-zero word. A result that reaches exponent 0 exactly is kept.
- R9: An operand with mantissa bit 8 clear counts as zero. If only one operand is zero, the other passes to the output bit for bit. If both are zero, the output is the all-zero word.
- R10: The block is purely combinational. The output follows a change of the inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 18 | First operand word |
| b | input | 18 | Second operand word |
| y | output | 18 | Sum word |

## Verification
The bench targets the carry-out boundary, where a missing one-bit right shift would wrap the mantissa and give a value near half the true sum. It targets the alignment edge at gap 8 versus gap 9, where an off-by-one shifter would leak a stray low bit or drop a real one. It also targets the exponent-floor boundary, where a wrong comparison would either wrap the exponent to a huge value or flush a legal result at exponent 0. Opposite-sign cases whose larger operand wins only on mantissa, together with every vector applied in both input orders, expose a design that takes the sign or the exponent from the wrong operand. Zero operands that carry garbage exponents catch a pass-through that normalises or clears a value it should leave alone.

// File: rtl/nfp_pkg.sv
package nfp_pkg;

    localparam int EXP_W  = 8;
    localparam int MAN_W  = 9;
    localparam int WORD_W = 1 + EXP_W + MAN_W;
    localparam int SHF_W  = $clog2(MAN_W);
    localparam int LZC_W  = $clog2(MAN_W + 1);

    typedef struct packed {
        logic             sgn;
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] man;
    } nfp_t;

    typedef enum logic [1:0] {
        RT_ZERO  = 2'd0,
        RT_TAKEA = 2'd1,
        RT_TAKEB = 2'd2,
        RT_ARITH = 2'd3
    } route_e;

    typedef struct packed {
        nfp_t             big;
        logic [MAN_W-1:0] small_man;
        logic [EXP_W-1:0] gap;
        logic             opp;
    } ordered_t;

    // a word without its top mantissa bit carries no value
    function automatic logic is_zero(nfp_t w);
        return !w.man[MAN_W-1];
    endfunction

    // magnitude order: exponent first, mantissa second
    function automatic logic mag_ge(nfp_t x, nfp_t z);
        return {x.exp, x.man} >= {z.exp, z.man};
    endfunction

    // number of zero bits above the highest one; MAN_W for an empty vector
    function automatic logic [LZC_W-1:0] lead_zeros(logic [MAN_W-1:0] v);
        logic [LZC_W-1:0] n;
        n = LZC_W'(MAN_W);
        for (int i = 0; i < MAN_W; i++) begin
            if (v[i]) n = LZC_W'(MAN_W - 1 - i);
        end
        return n;
    endfunction

endpackage

// File: rtl/nfp_order.sv
module nfp_order
    import nfp_pkg::*;
(
    input  nfp_t     a_i,
    input  nfp_t     b_i,
    output ordered_t ord_o
);

    logic a_first;
    nfp_t hi, lo;

    always_comb begin
        a_first = mag_ge(a_i, b_i);
        hi      = a_first ? a_i : b_i;
        lo      = a_first ? b_i : a_i;

        ord_o.big       = hi;
        ord_o.small_man = lo.man;
        ord_o.gap       = hi.exp - lo.exp;
        ord_o.opp       = hi.sgn ^ lo.sgn;
    end

    // R6: the operand kept as the larger one really is not smaller
    always_comb begin
        a_r6_order_holds: assert ({ord_o.big.exp, ord_o.big.man} >= {lo.exp, lo.man})
            else $error("R6 ordering put the smaller operand first");
    end

endmodule

// File: rtl/nfp_align.sv
module nfp_align
    import nfp_pkg::*;
(
    input  logic [MAN_W-1:0] man_i,
    input  logic [EXP_W-1:0] gap_i,
    output logic [MAN_W-1:0] man_o
);

    localparam int STAGES = SHF_W;

    logic [MAN_W-1:0] stage [STAGES+1];
    logic             far;

    assign stage[0] = man_i;

    // logarithmic right shifter, one stage per bit of the shift amount
    for (genvar gi = 0; gi < STAGES; gi++) begin : g_shift
        assign stage[gi+1] = gap_i[gi] ? (stage[gi] >> (1 << gi)) : stage[gi];
    end

    assign far   = gap_i >= EXP_W'(MAN_W);
    assign man_o = far ? '0 : stage[STAGES];

    // R4: alignment only ever loses bits, and a wide gap clears the operand
    always_comb begin
        a_r4_shift_shrinks: assert (man_o <= man_i)
            else $error("R4 aligned mantissa grew");
        a_r4_far_gap_zero: assert (!far || man_o == '0)
            else $error("R4 wide gap left bits behind");
    end

endmodule

// File: rtl/nfp_normalize.sv
module nfp_normalize
    import nfp_pkg::*;
(
    input  nfp_t             big_i,
    input  logic [MAN_W-1:0] small_i,
    input  logic             opp_i,
    output nfp_t             res_o
);

    logic [MAN_W:0]   sum;
    logic [MAN_W-1:0] dif;
    logic [LZC_W-1:0] lz;
    logic             cancel;
    logic             floor_hit;

    always_comb begin
        sum       = {1'b0, big_i.man} + {1'b0, small_i};
        dif       = big_i.man - small_i;
        lz        = lead_zeros(dif);
        cancel    = (dif == '0);
        floor_hit = EXP_W'(lz) > big_i.exp;

        res_o = '0;
        if (!opp_i) begin
            res_o.sgn = big_i.sgn;
            if (sum[MAN_W]) begin
                res_o.exp = big_i.exp + 1'b1;
                res_o.man = sum[MAN_W:1];
            end else begin
                res_o.exp = big_i.exp;
                res_o.man = sum[MAN_W-1:0];
            end
        end else if (!cancel && !floor_hit) begin
            res_o.sgn = big_i.sgn;
            res_o.exp = big_i.exp - EXP_W'(lz);
            res_o.man = dif << lz;
        end
    end

    // R5 / R8: a difference never raises the exponent; a kept one is normalised
    always_comb begin
        a_r5_exp_not_raised: assert (!opp_i || res_o.exp <= big_i.exp)
            else $error("R5 subtraction raised the exponent");
        a_r8_flush_or_norm: assert (res_o.man[MAN_W-1] || res_o == '0)
            else $error("R8 unnormalised result was not flushed");
    end

endmodule

// File: rtl/nfp_add.sv
module nfp_add
    import nfp_pkg::*;
(
    input  logic [17:0] a,
    input  logic [17:0] b,
    output logic [17:0] y
);

    nfp_t             wa, wb, arith;
    ordered_t         ord;
    logic [MAN_W-1:0] small_al;
    route_e           route;

    assign wa = nfp_t'(a);
    assign wb = nfp_t'(b);

    nfp_order u_order (
        .a_i   (wa),
        .b_i   (wb),
        .ord_o (ord)
    );

    nfp_align u_align (
        .man_i (ord.small_man),
        .gap_i (ord.gap),
        .man_o (small_al)
    );

    nfp_normalize u_norm (
        .big_i   (ord.big),
        .small_i (small_al),
        .opp_i   (ord.opp),
        .res_o   (arith)
    );

    always_comb begin
        unique case ({is_zero(wa), is_zero(wb)})
            2'b11:   route = RT_ZERO;
            2'b10:   route = RT_TAKEB;
            2'b01:   route = RT_TAKEA;
            default: route = RT_ARITH;
        endcase
    end

    always_comb begin
        unique case (route)
            RT_ZERO:  y = '0;
            RT_TAKEB: y = b;
            RT_TAKEA: y = a;
            default:  y = arith;
        endcase
    end

    // port-level checks
    always_comb begin
        a_r1_normal_or_zero: assert (y[MAN_W-1] || y == '0)
            else $error("R1 output neither normalised nor zero");
        a_r9_pass_other: assert (!(is_zero(wa) && !is_zero(wb)) || y == b)
            else $error("R9 zero operand altered the other");
        a_r7_cancel_zero: assert (!(!is_zero(wa) && a[16:0] == b[16:0] && a[17] != b[17]) || y == '0)
            else $error("R7 exact cancellation not zero");
        a_r6_sign_of_larger: assert (is_zero(wa) || is_zero(wb) || y == '0 ||
                                     y[17] == (mag_ge(wa, wb) ? a[17] : b[17]))
            else $error("R6 sign not taken from the larger operand");
    end

endmodule

// File: tb/sim_nfp_add.sv
module sim_nfp_add;

    localparam int W  = 18;
    localparam int NV = 17;
    localparam int EW = 4 + 3 * W;

    logic         clk = 1'b0;
    logic [W-1:0] a, b;
    logic [W-1:0] y;
    int           n_chk  = 0;
    int           n_fail = 0;
    int           cyc    = 0;

    always #2 clk = ~clk;   // 250 MHz

    nfp_add u0 (.a(a), .b(b), .y(y));

    // {req, a, b, expected}; words as {sign, exponent, mantissa}
    localparam logic [EW-1:0] VEC [NV] = '{
        {4'd3,  1'b0,8'd129,9'd256, 1'b0,8'd129,9'd256, 1'b0,8'd130,9'd256}, // R3 1+1
        {4'd2,  1'b0,8'd129,9'd256, 1'b0,8'd128,9'd256, 1'b0,8'd129,9'd384}, // R2 1+0.5
        {4'd5,  1'b0,8'd129,9'd384, 1'b1,8'd128,9'd256, 1'b0,8'd129,9'd256}, // R5 1.5-0.5
        {4'd6,  1'b0,8'd128,9'd256, 1'b1,8'd128,9'd384, 1'b1,8'd127,9'd256}, // R6 0.5-0.75
        {4'd7,  1'b0,8'd130,9'd300, 1'b1,8'd130,9'd300, 1'b0,8'd0,  9'd0  }, // R7
        {4'd4,  1'b0,8'd140,9'd256, 1'b0,8'd131,9'd511, 1'b0,8'd140,9'd256}, // R4 gap 9
        {4'd4,  1'b0,8'd140,9'd256, 1'b0,8'd132,9'd511, 1'b0,8'd140,9'd257}, // R4 gap 8
        {4'd9,  1'b0,8'd77, 9'd0,   1'b1,8'd133,9'd300, 1'b1,8'd133,9'd300}, // R9
        {4'd9,  1'b1,8'd120,9'd400, 1'b0,8'd0,  9'd5,   1'b1,8'd120,9'd400}, // R9
        {4'd9,  1'b0,8'd10, 9'd7,   1'b1,8'd20, 9'd255, 1'b0,8'd0,  9'd0  }, // R9 both
        {4'd8,  1'b0,8'd2,  9'd256, 1'b1,8'd2,  9'd257, 1'b0,8'd0,  9'd0  }, // R8 floor
        {4'd8,  1'b0,8'd8,  9'd256, 1'b1,8'd8,  9'd257, 1'b1,8'd0,  9'd256}, // R8 exp 0 kept
        {4'd3,  1'b1,8'd129,9'd511, 1'b1,8'd129,9'd511, 1'b1,8'd130,9'd511}, // R3 lsb drop
        {4'd5,  1'b1,8'd135,9'd400, 1'b0,8'd135,9'd300, 1'b1,8'd133,9'd400}, // R5 two shifts
        {4'd4,  1'b0,8'd131,9'd256, 1'b1,8'd129,9'd259, 1'b0,8'd130,9'd384}, // R4 truncation
        {4'd1,  1'b0,8'd128,9'd256, 1'b0,8'd127,9'd256, 1'b0,8'd128,9'd384}, // R1 0.5+0.25
        {4'd1,  1'b0,8'd130,9'd256, 1'b1,8'd129,9'd256, 1'b0,8'd129,9'd256}  // R1 2-1
    };

    task automatic check(input int req, input logic [W-1:0] got, input logic [W-1:0] exp_v);
        n_chk++;
        if (got !== exp_v) begin
            n_fail++;
            $display("FAIL R%0d a=%h b=%h got=%h expected=%h", req, a, b, got, exp_v);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        a = '0;
        b = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(9, y, '0);   // R9: idle all-zero inputs give zero

        for (int i = 0; i < NV; i++) begin
            @(posedge clk);
            a = VEC[i][3*W-1:2*W];
            b = VEC[i][2*W-1:W];
            @(negedge clk);
            check(int'(VEC[i][EW-1:3*W]), y, VEC[i][W-1:0]);
            @(posedge clk);   // R6: swapped order must match
            a = VEC[i][2*W-1:W];
            b = VEC[i][3*W-1:2*W];
            @(negedge clk);
            check(6, y, VEC[i][W-1:0]);
        end

        // R10: output settles between edges without a clock
        @(negedge clk);
        a = {1'b0, 8'd129, 9'd256};
        b = {1'b0, 8'd129, 9'd256};
        #1 check(10, y, {1'b0, 8'd130, 9'd256});
        b = {1'b1, 8'd129, 9'd256};
        #0.5 check(10, y, '0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule